// File: doc/BRIEF.md
# Quad DAC Serial Register Controller

This block is the digital front end of a four-channel, 12-bit converter. A host writes it over a three-wire serial port made of a serial clock, a data line and an active-low select. Each 16-bit command word carries a 2-bit channel address, two unused bits and a 12-bit code. A separate active-low load strobe copies the code field into one of four channel holding registers. The four registers drive the converter ladders as four parallel 12-bit codes.

An active-low clear input forces every holding register to one of two values, picked by a clear-select pin: zero-scale (0x000) or midscale (0x800). Clear does not touch the serial shift register. The next load strobe after clear can therefore restore a channel from the word that was already shifted in.

All host pins are sampled by a system clock that runs at least four times faster than the serial clock. Edges are found on the synchronized copies. The select pin and the serial clock are combined by an OR gate before edge detection. A rising edge on select while the serial clock is low therefore shifts in one extra bit.

Top module: `qdac_front`

## Requirements
- R1: After reset, all four channel codes are 0x000, the shift register holds 0x0000, frame_done_o is 0 and proto_err_o is 0.
- R2: A word is shifted in MSB first, one bit per rising edge of the merged shift clock. Wire order is A1, A0, two unused bits, then D11 down to D0, so the address sits in word bits [15:14] and the code in bits [11:0]. A falling edge of load_n_i copies the code into the addressed channel.
- R3: Address 0 selects codes_o[0], 1 selects codes_o[1], 2 selects codes_o[2] and 3 selects codes_o[3]. The other channels are left unchanged.
- R4: While ser_sel_n_i is high, toggling ser_clk_i does not change the shift register.
- R5: The shift clock is ser_clk_i OR ser_sel_n_i. A rising edge on select while the serial clock is low shifts in the current data bit as one extra bit.
- R6: A load strobe acts whatever the level of ser_sel_n_i, including while select is still low.
- R7: While clr_n_i is low, all four codes are 0x000 if clr_mid_i is 0, or 0x800 if clr_mid_i is 1.
- R8: Clear leaves the shift register unchanged. After clear is released, the codes keep the clear value until the next load falling edge, which reloads from the shift register.
- R9: When a load falling edge and an active clear reach the block in the same system cycle, the clear value wins.
- R10: A shift edge while load_n_i is low sets proto_err_o. The flag stays set until reset, and the shift still takes place.
- R11: A select falling edge resets the bit counter. frame_done_o is 1 once at least 16 shifts have occurred since then. In an over-long frame the shift register keeps the last 16 bits.
- R12: The bit counter does not gate loading. A load after a partial frame uses the shift register as it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; idles high |
| ser_dat_i | input | 1 | Serial data |
| ser_sel_n_i | input | 1 | Active-low serial select |
| load_n_i | input | 1 | Active-low load strobe; acts on its falling edge |
| clr_n_i | input | 1 | Active-low level clear |
| clr_mid_i | input | 1 | Clear value select: 0 gives zero-scale, 1 gives midscale |
| codes_o | output | 4x12 | Channel holding registers, index = address |
| frame_done_o | output | 1 | At least 16 shifts since the last select fall |
| proto_err_o | output | 1 | Sticky: a shift occurred while load was low |

## Verification
The hardest situations to reach are the ones that depend on edges lining up on the same system cycle, and the ones whose effect is hidden inside the shift register.

For the clear-versus-load race, the stimulus changes clear and load on the same system-clock edge. Both pass through identical synchronizer depth, so they reach the channel registers together.

Shift-register contents are never visible directly. The bench exposes them in two ways. First, it raises select while the serial clock is held low, which injects the 16th bit. Second, it applies clear or ignored clock toggles and follows them with a bare load strobe; the word that lands in a channel then shows exactly which bits were shifted in.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // bit positions inside the synchronized host-pin vector
  typedef enum int unsigned {
    PIN_SCLK  = 0,
    PIN_SEL   = 1,
    PIN_LOAD  = 2,
    PIN_CLR   = 3,
    PIN_DAT   = 4,
    PIN_MID   = 5,
    PIN_COUNT = 6
  } pin_idx_e;

  // idle levels: strobes and serial clock high, data and mid select low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b00_1111;

  function automatic logic [31:0] mid_code(input int unsigned width);
    mid_code = 32'd1 << (width - 1);
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned    W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      stab_q <= RST;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int unsigned WW = 16,
  localparam int unsigned CW = $clog2(WW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          sel_s,
  input  logic          dat_s,
  output logic [WW-1:0] word_o,
  output logic          shift_o,
  output logic          done_o
);
  logic          merged;
  logic          merged_d, merged_d_nxt;
  logic          sel_d, sel_d_nxt;
  logic [WW-1:0] word_q, word_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          shift_en;
  logic          sel_fall;

  // select is folded into the shift clock the same way an OR gate would
  assign merged   = sclk_s | sel_s;
  assign shift_en = merged & ~merged_d;
  assign sel_fall = ~sel_s & sel_d;

  always_comb begin
    merged_d_nxt = merged;
    sel_d_nxt    = sel_s;
    word_nxt     = word_q;
    cnt_nxt      = cnt_q;
    if (shift_en) begin
      word_nxt = {word_q[WW-2:0], dat_s};
    end
    if (sel_fall) begin
      cnt_nxt = '0;
    end else if (shift_en && (cnt_q != CW'(WW))) begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merged_d <= 1'b1;
      sel_d    <= 1'b1;
      word_q   <= '0;
      cnt_q    <= '0;
    end else begin
      merged_d <= merged_d_nxt;
      sel_d    <= sel_d_nxt;
      word_q   <= word_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  assign word_o  = word_q;
  assign shift_o = shift_en;
  assign done_o  = (cnt_q == CW'(WW));
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  localparam int unsigned AW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_s,
  input  logic                    clr_s,
  input  logic                    mid_s,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           data,
  output logic                    load_fall_o,
  output logic [NCH-1:0][DW-1:0]  codes_o
);
  localparam logic [DW-1:0] MID = DW'(qdac_pkg::mid_code(DW));

  logic                   load_d, load_d_nxt;
  logic                   load_fall;
  logic [DW-1:0]          clr_val;
  logic [NCH-1:0][DW-1:0] code_q, code_nxt;

  assign load_fall  = ~load_s & load_d;
  assign clr_val    = mid_s ? MID : '0;
  assign load_d_nxt = load_s;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_comb begin
      if (!clr_s) begin
        code_nxt[g] = clr_val;
      end else if (load_fall && (addr == AW'(g))) begin
        code_nxt[g] = data;
      end else begin
        code_nxt[g] = code_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d <= 1'b1;
      code_q <= '0;
    end else begin
      load_d <= load_d_nxt;
      code_q <= code_nxt;
    end
  end

  assign load_fall_o = load_fall;
  assign codes_o     = code_q;
endmodule

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 12,
  parameter int unsigned PADW = 2,
  localparam int unsigned AW  = $clog2(NCH),
  localparam int unsigned WW  = AW + PADW + DW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_dat_i,
  input  logic                   ser_sel_n_i,
  input  logic                   load_n_i,
  input  logic                   clr_n_i,
  input  logic                   clr_mid_i,
  output logic [NCH-1:0][DW-1:0] codes_o,
  output logic                   frame_done_o,
  output logic                   proto_err_o
);
  import qdac_pkg::*;

  logic [1:0]           rst_ff;
  logic                 rst_q;
  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic [WW-1:0]        word;
  logic                 shift_pulse;
  logic                 load_fall;
  logic                 err_q, err_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q = rst_ff[1];

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = ser_clk_i;
    pins_raw[PIN_SEL]  = ser_sel_n_i;
    pins_raw[PIN_LOAD] = load_n_i;
    pins_raw[PIN_CLR]  = clr_n_i;
    pins_raw[PIN_DAT]  = ser_dat_i;
    pins_raw[PIN_MID]  = clr_mid_i;
  end

  qdac_sync #(.W(PIN_COUNT), .RST(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_q),
    .d    (pins_raw),
    .q    (pins_s)
  );

  qdac_shift #(.WW(WW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_q),
    .sclk_s (pins_s[PIN_SCLK]),
    .sel_s  (pins_s[PIN_SEL]),
    .dat_s  (pins_s[PIN_DAT]),
    .word_o (word),
    .shift_o(shift_pulse),
    .done_o (frame_done_o)
  );

  qdac_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_q),
    .load_s     (pins_s[PIN_LOAD]),
    .clr_s      (pins_s[PIN_CLR]),
    .mid_s      (pins_s[PIN_MID]),
    .addr       (word[WW-1 -: AW]),
    .data       (word[DW-1:0]),
    .load_fall_o(load_fall),
    .codes_o    (codes_o)
  );

  // sticky flag: a bit arrived while the load strobe was held low
  always_comb begin
    err_nxt = err_q;
    if (shift_pulse && !pins_s[PIN_LOAD]) err_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) err_q <= 1'b0;
    else        err_q <= err_nxt;
  end

  assign proto_err_o = err_q;
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 12,
  parameter int unsigned WW  = 16
) (
  input logic                   clk,
  input logic                   rst_q,
  input logic [5:0]             pins_s,
  input logic [WW-1:0]          word,
  input logic                   load_fall,
  input logic [NCH-1:0][DW-1:0] codes_o,
  input logic                   frame_done_o,
  input logic                   proto_err_o
);
  localparam int unsigned AW = $clog2(NCH);
  localparam logic [DW-1:0] MID = DW'(qdac_pkg::mid_code(DW));
  logic sel_s, clr_s, mid_s;
  assign sel_s = pins_s[1];
  assign clr_s = pins_s[3];
  assign mid_s = pins_s[5];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    // R2
    load_route_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (load_fall && clr_s && (word[WW-1 -: AW] == AW'(g))) |=> (codes_o[g] == $past(word[DW-1:0])));
    // R7
    clear_value_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (!clr_s) |=> (codes_o[g] == ($past(mid_s) ? MID : '0)));
    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (!clr_s && load_fall && !mid_s) |=> (codes_o[g] == '0));
  end

  // R4
  sel_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_s && $past(sel_s)) |=> $stable(word));
  // R8
  hold_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (clr_s && !load_fall) |=> $stable(codes_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q)
    proto_err_o |=> proto_err_o);
  // R11
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(sel_s) |=> !frame_done_o);
endmodule

bind qdac_front qdac_front_chk #(.NCH(NCH), .DW(DW), .WW(WW)) u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .pins_s      (pins_s),
  .word        (word),
  .load_fall   (load_fall),
  .codes_o     (codes_o),
  .frame_done_o(frame_done_o),
  .proto_err_o (proto_err_o)
);

// File: tb/qdac_front_bench.sv
module qdac_front_bench;
  localparam int NCH = 4;
  localparam int DW  = 12;

  typedef struct {
    logic [NCH*DW-1:0] codes;
    logic              done;
    logic              err;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_dat = 1'b0, sel_n = 1'b1;
  logic load_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
  logic [NCH-1:0][DW-1:0] codes;
  logic frame_done, proto_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  // bench-side model built from the requirements
  logic [15:0]   m_sh;
  logic [DW-1:0] m_code [NCH];
  int            m_cnt;
  logic          m_err;
  logic          m_clr_active;

  always #10 clk = ~clk;

  qdac_front u_qdac_front (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_sel_n_i(sel_n), .load_n_i(load_n), .clr_n_i(clr_n), .clr_mid_i(clr_mid),
    .codes_o(codes), .frame_done_o(frame_done), .proto_err_o(proto_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    for (int i = 0; i < NCH; i++) e.codes[i*DW +: DW] = m_code[i];
    e.done = (m_cnt >= 16);
    e.err  = m_err;
    e.tag  = tag;
    sb_q.push_back(e);
    tick(1);
  endtask

  task automatic model_shift(input logic b);
    m_sh = {m_sh[14:0], b};
    if (m_cnt < 16) m_cnt++;
    if (!load_n) m_err = 1'b1;
  endtask

  task automatic sel_low();
    sel_n = 1'b0; m_cnt = 0; tick(6);
  endtask

  task automatic send_bit(input logic b);
    ser_clk = 1'b0; ser_dat = b; tick(4);
    ser_clk = 1'b1; model_shift(b); tick(4);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_word(input logic [1:0] a, input logic [DW-1:0] d);
    sel_low();
    send_bits({16'h0, a, 2'b00, d}, 16);
    sel_n = 1'b1; tick(6);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; tick(6);
    if (!m_clr_active) m_code[m_sh[15:14]] = m_sh[11:0];
    load_n = 1'b1; tick(6);
  endtask

  task automatic apply_clear(input logic mid);
    clr_mid = mid; tick(2);
    clr_n = 1'b0; m_clr_active = 1'b1;
    for (int i = 0; i < NCH; i++) m_code[i] = mid ? 12'h800 : 12'h000;
    tick(6);
  endtask

  task automatic release_clear();
    clr_n = 1'b1; m_clr_active = 1'b0; tick(6);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      for (int i = 0; i < NCH; i++) begin
        n_checks++;
        if (codes[i] !== e.codes[i*DW +: DW]) begin
          n_fail++;
          $display("FAIL %s channel %0d: got %h expected %h", e.tag, i, codes[i], e.codes[i*DW +: DW]);
        end
      end
      n_checks++;
      if (frame_done !== e.done) begin
        n_fail++;
        $display("FAIL %s frame_done: got %b expected %b", e.tag, frame_done, e.done);
      end
      n_checks++;
      if (proto_err !== e.err) begin
        n_fail++;
        $display("FAIL %s proto_err: got %b expected %b", e.tag, proto_err, e.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_sh = '0; m_cnt = 0; m_err = 1'b0; m_clr_active = 1'b0;
    for (int i = 0; i < NCH; i++) m_code[i] = '0;
    tick(5); rst_n = 1'b1; tick(6);
    push_exp("R1");

    // R2 R3: one word per channel
    send_word(2'd0, 12'hA5C); pulse_load(); push_exp("R2");
    send_word(2'd1, 12'h3B1); pulse_load(); push_exp("R3");
    send_word(2'd2, 12'hFFF); pulse_load(); push_exp("R3");
    send_word(2'd3, 12'h001); pulse_load(); push_exp("R3");

    // R4: clock toggles with select high, then prove word unchanged
    ser_dat = 1'b1;
    for (int i = 0; i < 5; i++) begin ser_clk = 1'b0; tick(4); ser_clk = 1'b1; tick(4); end
    apply_clear(1'b1); push_exp("R7");
    release_clear(); push_exp("R8");
    pulse_load(); push_exp("R4");

    // R7 zero-scale, R8 hold then reload of the old word
    apply_clear(1'b0); push_exp("R7");
    release_clear(); push_exp("R8");
    pulse_load(); push_exp("R8");

    // R5: 16th bit injected by select rising while serial clock low
    sel_low();
    send_bits({16'h0, 2'd1, 2'b00, 12'h7E5}, 15);
    ser_clk = 1'b0; ser_dat = 1'b1; tick(4);
    sel_n = 1'b1; model_shift(1'b1); tick(4);
    ser_clk = 1'b1; tick(6);
    push_exp("R11");
    pulse_load(); push_exp("R5");

    // R6: load while select still low
    sel_low();
    send_bits({16'h0, 2'd2, 2'b00, 12'h19C}, 16);
    pulse_load(); push_exp("R6");
    sel_n = 1'b1; tick(6);

    // R12: partial frame, done stays low, load uses current contents
    sel_low(); send_bits(32'h2D5, 10); sel_n = 1'b1; tick(6);
    push_exp("R11");
    pulse_load(); push_exp("R12");

    // R11: over-long frame keeps the last 16 bits
    sel_low();
    send_bits({12'h0, 4'hF, 2'd0, 2'b11, 12'h6A2}, 20);
    sel_n = 1'b1; tick(6);
    pulse_load(); push_exp("R11");

    // R9: clear and load fall in the same cycle
    send_word(2'd3, 12'hBEE);
    clr_mid = 1'b1; tick(2);
    clr_n = 1'b0; load_n = 1'b0; m_clr_active = 1'b1;
    for (int i = 0; i < NCH; i++) m_code[i] = 12'h800;
    tick(6); push_exp("R9");
    release_clear(); push_exp("R9");
    load_n = 1'b1; tick(6); push_exp("R9");

    // R10: shift while load held low; flag sticks
    load_n = 1'b0; tick(6);
    m_code[m_sh[15:14]] = m_sh[11:0];
    sel_low(); send_bit(1'b0); sel_n = 1'b1; tick(6);
    load_n = 1'b1; tick(6);
    push_exp("R10");
    send_word(2'd0, 12'h444); pulse_load(); push_exp("R10");

    wait (sb_q.size() == 0);
    tick(2);
    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule